// File: doc/BRIEF.md
# MASH 1-1-1 Divide-Ratio Modulator

This block produces the per-reference-cycle integer divide value for a fractional-N frequency synthesizer. An unsigned fractional control word is fed into three first-order accumulators in cascade. Each accumulator after the first adds the residue (sum output) of the stage before it to its own stored value. The three carry bits are merged by digital cancellation logic into a small signed offset. That offset is added to a base integer and registered as the divide value. Only the quantization noise of the last stage remains in the result, shaped to third order.

The block has no feedback paths that can build up, so it is stable for every input word. The residue held in the third accumulator is also brought out unprocessed as an error tap. A downstream cancellation path can use it directly, with no further requantizer or triple differentiator. The divider, charge pump and loop filter are outside this block.

Top module: `mash111_mod`

## Requirements
- R1: While `rst` is high at a rising clock edge, every accumulator and history register is cleared. At that edge `div_o` and `err_o` both become 0.
- R2: On every enabled edge the first accumulator takes the value (stored value + `frac_i`) mod 2^ACC_W. Its carry is 1 exactly when that addition overflows.
- R3: On the same edge the second accumulator adds the new first-stage residue to its stored value, mod 2^ACC_W, and the third accumulator adds the new second-stage residue. Each stage produces a carry on overflow.
- R4: The signed offset is c1 + (c2 − c2') + (c3 − 2·c3' + c3''). Here a prime marks the carry from the previous enabled edge and a double prime the one before that, and carries from before reset count as 0. The offset always lies in −3..+4.
- R5: On an enabled edge `div_o` becomes (`base_i` + offset) mod 2^INT_W, using the `base_i` present before that edge.
- R6: On an enabled edge `err_o` becomes the new residue of the third accumulator.
- R7: While `en` is low, no accumulator or history register changes and `div_o` and `err_o` hold their values, whatever `frac_i` and `base_i` do.
- R8: Starting from reset, the sum of the offsets over N enabled edges differs from N·`frac_i`/2^ACC_W by less than 4.
- R9: With `frac_i` = 0 from reset, every offset is 0, so `div_o` follows `base_i` one edge later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advances the modulator by one step when high |
| frac_i | input | ACC_W | Unsigned fractional control word |
| base_i | input | INT_W | Base integer divide value |
| div_o | output | INT_W | Registered divide value (base plus signed offset) |
| err_o | output | ACC_W | Unprocessed residue of the last accumulator |

## Verification
Both `div_o` and `err_o` change one rising edge after the inputs that produce them are applied. No other register stands between the inputs and either output. The bench applies new inputs on the falling edge and samples both outputs 1 ns after the next rising edge. At that point it compares them with a behavioural model that it has advanced by one step for that edge. For cycles with `en` low, the model does not advance, so the same sampling shows that the outputs held. The R8 and R9 checks accumulate the offsets read back from `div_o` minus the base that was applied in the same cycle.

// File: rtl/mash_pkg.sv
package mash_pkg;

    // Default widths of the fractional accumulators and of the integer divide value
    localparam int DEF_ACC_W = 20;
    localparam int DEF_INT_W = 8;

    // Signed offset from the cancellation logic, range -3..+4
    typedef logic signed [3:0] mash_off_t;

    // Carry history used by the cancellation logic
    typedef struct packed {
        logic c2_p;    // stage-2 carry, one step back
        logic c3_p;    // stage-3 carry, one step back
        logic c3_pp;   // stage-3 carry, two steps back
    } mash_hist_t;

endpackage

// File: rtl/mash_acc_stage.sv
module mash_acc_stage #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] in_i,
    output logic [W-1:0] sum_o,
    output logic         carry_o,
    output logic [W-1:0] res_q_o
);

    typedef struct packed {
        logic [W-1:0] acc;
    } stage_t;

    stage_t       st_d, st_q;
    logic [W:0]   add_w;

    always_comb begin
        add_w = {1'b0, st_q.acc} + {1'b0, in_i};
        st_d  = st_q;
        if (en) begin
            st_d.acc = add_w[W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sum_o   = add_w[W-1:0];
    assign carry_o = add_w[W];
    assign res_q_o = st_q.acc;

endmodule

// File: rtl/mash_cancel.sv
module mash_cancel
    import mash_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  logic      c1_i,
    input  logic      c2_i,
    input  logic      c3_i,
    output mash_off_t off_o
);

    mash_hist_t h_d, h_q;
    logic [3:0] sum_w;

    always_comb begin
        // Modulo-16 arithmetic; the bit pattern is the two's complement offset
        sum_w = 4'(c1_i)
              + 4'(c2_i) - 4'(h_q.c2_p)
              + 4'(c3_i) - 4'({h_q.c3_p, 1'b0}) + 4'(h_q.c3_pp);

        h_d = h_q;
        if (en) begin
            h_d.c2_p  = c2_i;
            h_d.c3_pp = h_q.c3_p;
            h_d.c3_p  = c3_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            h_q <= '0;
        end else begin
            h_q <= h_d;
        end
    end

    assign off_o = mash_off_t'(sum_w);

endmodule

// File: rtl/mash111_mod.sv
module mash111_mod
    import mash_pkg::*;
#(
    parameter int ACC_W = DEF_ACC_W,
    parameter int INT_W = DEF_INT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [ACC_W-1:0] frac_i,
    input  logic [INT_W-1:0] base_i,
    output logic [INT_W-1:0] div_o,
    output logic [ACC_W-1:0] err_o
);

    localparam int NSTAGE = 3;
    localparam int LAST   = NSTAGE - 1;

    typedef struct packed {
        logic [INT_W-1:0] div;
    } out_t;

    logic [ACC_W-1:0]  st_in  [NSTAGE];
    logic [ACC_W-1:0]  st_sum [NSTAGE];
    logic [ACC_W-1:0]  st_res [NSTAGE];
    logic [NSTAGE-1:0] carry_w;
    mash_off_t         off_w;
    out_t              o_d, o_q;

    for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
        if (g == 0) begin : g_head
            assign st_in[g] = frac_i;
        end else begin : g_chain
            assign st_in[g] = st_sum[g-1];
        end

        mash_acc_stage #(.W(ACC_W)) u_acc (
            .clk     (clk),
            .rst     (rst),
            .en      (en),
            .in_i    (st_in[g]),
            .sum_o   (st_sum[g]),
            .carry_o (carry_w[g]),
            .res_q_o (st_res[g])
        );
    end

    mash_cancel u_cancel (
        .clk   (clk),
        .rst   (rst),
        .en    (en),
        .c1_i  (carry_w[0]),
        .c2_i  (carry_w[1]),
        .c3_i  (carry_w[2]),
        .off_o (off_w)
    );

    always_comb begin
        o_d = o_q;
        if (en) begin
            o_d.div = base_i + INT_W'(off_w);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign div_o = o_q.div;
    assign err_o = st_res[LAST];

endmodule

// File: rtl/mash111_mod_chk.sv
module mash111_mod_chk
    import mash_pkg::*;
#(
    parameter int ACC_W = DEF_ACC_W,
    parameter int INT_W = DEF_INT_W
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic [INT_W-1:0] base_i,
    input logic [INT_W-1:0] div_o,
    input logic [ACC_W-1:0] err_o,
    input mash_off_t        off
);

    logic [INT_W-1:0] div_exp_w;
    assign div_exp_w = base_i + INT_W'(off);

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (div_o == '0 && err_o == '0));

    p_offset_range_r4: assert property (@(posedge clk) disable iff (rst)
        (off >= -4'sd3 && off <= 4'sd4));

    p_div_sum_r5: assert property (@(posedge clk) disable iff (rst)
        en |=> (div_o == $past(div_exp_w)));

    p_hold_outputs_r7: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(div_o) && $stable(err_o)));

endmodule

bind mash111_mod mash111_mod_chk #(.ACC_W(ACC_W), .INT_W(INT_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .base_i (base_i),
    .div_o  (div_o),
    .err_o  (err_o),
    .off    (off_w)
);

// File: tb/mash111_mod_test.sv
`timescale 1ns/1ps
module mash111_mod_test;

    localparam int ACC_W = 20;
    localparam int INT_W = 8;
    localparam longint MODA = 64'd1 << ACC_W;
    localparam int MODI = 1 << INT_W;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             en = 1'b0;
    logic [ACC_W-1:0] frac = '0;
    logic [INT_W-1:0] base = '0;
    logic [INT_W-1:0] div_o;
    logic [ACC_W-1:0] err_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // Behavioural reference state
    longint a1 = 0, a2 = 0, a3 = 0;
    int     c2_last = 0;
    int     c3_hist[$] = '{0, 0};   // [0] = one step back, [1] = two steps back
    int     exp_div = 0;
    longint exp_err = 0;
    int     last_off = 0;

    mash111_mod #(.ACC_W(ACC_W), .INT_W(INT_W)) uut (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .frac_i (frac),
        .base_i (base),
        .div_o  (div_o),
        .err_o  (err_o)
    );

    always #5 clk = ~clk;

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles, expected fewer than 200000", cycles);
            report();
        end
    end

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        a1 = 0; a2 = 0; a3 = 0;
        c2_last = 0;
        c3_hist = '{0, 0};
        exp_div = 0;
        exp_err = 0;
    endtask

    task automatic model_step(input longint f, input int b);
        int c1, c2, c3, off;
        c1 = ((a1 + f) >= MODA) ? 1 : 0;
        a1 = (a1 + f) % MODA;
        c2 = ((a2 + a1) >= MODA) ? 1 : 0;
        a2 = (a2 + a1) % MODA;
        c3 = ((a3 + a2) >= MODA) ? 1 : 0;
        a3 = (a3 + a2) % MODA;
        off = c1 + (c2 - c2_last) + (c3 - 2 * c3_hist[0] + c3_hist[1]);
        c2_last = c2;
        c3_hist.push_front(c3);
        void'(c3_hist.pop_back());
        exp_div = ((b + off) % MODI + MODI) % MODI;
        exp_err = a3;
    endtask

    // Offset read from the ports: div minus the base applied, as signed INT_W value
    function automatic int port_off(input int b);
        int d;
        d = ((int'(div_o) - b) % MODI + MODI) % MODI;
        if (d >= MODI / 2) d = d - MODI;
        return d;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        en = 1'b0;
        @(posedge clk); #1;
        model_reset();
        check("R1 div after reset", div_o, 0);
        check("R1 err after reset", err_o, 0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // One clock: drive on falling edge, sample 1 ns after rising edge
    task automatic step(input logic e, input longint f, input int b, input string tag);
        @(negedge clk);
        en = e;
        frac = ACC_W'(f);
        base = INT_W'(b);
        @(posedge clk); #1;
        if (e) begin
            model_step(f, b);
            last_off = port_off(b);
            checks++;
            if (last_off < -3 || last_off > 4) begin
                errors++;
                $display("FAIL R4 offset range: actual %0d expected -3..4", last_off);
            end
        end
        check({tag, " R5 div"}, div_o, exp_div);
        check({tag, " R6 err"}, err_o, exp_err);
    endtask

    initial begin
        longint sum_off;
        real    ideal, diff;

        // R1 reset state
        do_reset();

        // R9 zero fraction: offset stays zero, div follows base
        sum_off = 0;
        for (int i = 0; i < 40; i++) begin
            step(1'b1, 0, 17 + i, "R9");
            check("R9 zero offset", last_off, 0);
        end

        // R2/R3 half-scale and quarter-scale fractions
        do_reset();
        for (int i = 0; i < 64; i++) step(1'b1, MODA / 2, 50, "R2 half");
        do_reset();
        for (int i = 0; i < 64; i++) step(1'b1, MODA / 4 + 3, 50, "R3 quarter");

        // Near full scale and tiny fraction
        do_reset();
        for (int i = 0; i < 64; i++) step(1'b1, MODA - 1, 100, "R3 full");
        do_reset();
        for (int i = 0; i < 64; i++) step(1'b1, 1, 100, "R2 tiny");

        // R5 base wrap at the top and bottom of the integer range
        do_reset();
        for (int i = 0; i < 64; i++) step(1'b1, 987654, (i % 2 == 0) ? 255 : 1, "R5 wrap");

        // R7 enable low: inputs change, nothing moves
        for (int i = 0; i < 20; i++) step(1'b0, 1000 * i + 7, 3 * i, "R7 hold");
        for (int i = 0; i < 20; i++) step(1'b1, 321987, 40, "R7 resume");

        // Random fractions and bases with random enable gaps
        for (int i = 0; i < 600; i++) begin
            step(($urandom % 4) != 0, longint'($urandom % MODA), int'($urandom % MODI), "R3 random");
        end

        // R8 long-run average of the offset
        do_reset();
        sum_off = 0;
        for (int i = 0; i < 4096; i++) begin
            step(1'b1, 12345, 64, "R8 avg");
            sum_off += last_off;
        end
        ideal = 4096.0 * 12345.0 / real'(MODA);
        diff = real'(sum_off) - ideal;
        checks++;
        if (diff >= 4.0 || diff <= -4.0) begin
            errors++;
            $display("FAIL R8 average: actual %0d expected %f (+-4)", sum_off, ideal);
        end

        // R1 reset in the middle of activity
        for (int i = 0; i < 10; i++) step(1'b1, 555555, 9, "R1 pre");
        do_reset();
        step(1'b1, 0, 9, "R1 post");

        report();
    end

endmodule